// File: doc/BRIEF.md
# Eight-Mode Multifunction Shift Register

This block is a clocked register, four bits wide by default, whose next value is picked on every rising clock edge by a three-bit mode select. The eight modes cover holding, clearing, arithmetic and logical right shifts, a left shift fed from a serial input bit, a left rotate, a parallel load and a bitwise inversion. Arithmetic right shift treats the contents as a two's complement number.

Each bit has its own next-state selector that sees the bit itself, its neighbours, the parallel input bit and the serial input where it applies. The selectors feed one bank of edge-triggered flops. An active-high synchronous reset clears the register and overrides every mode. The output is always the stored value, so it changes only at a rising edge.

Top module: `msr_shift_reg`

## Requirements
- R1: Mode 3'b000 keeps the register value unchanged across the edge.
- R2: Mode 3'b001 loads all zeros.
- R3: Mode 3'b010 shifts right arithmetically: bit i takes old bit i+1 for i below WIDTH-1, and the top bit keeps its old value.
- R4: Mode 3'b011 shifts left: bit i takes old bit i-1 for i above 0, and bit 0 takes the serial input.
- R5: Mode 3'b100 rotates left: bit i takes old bit i-1 for i above 0, and bit 0 takes the old top bit.
- R6: Mode 3'b101 shifts right logically: bit i takes old bit i+1 for i below WIDTH-1, and the top bit becomes 0.
- R7: Mode 3'b110 loads the parallel bus, bit i taking input bit i.
- R8: Mode 3'b111 replaces every bit with its complement.
- R9: With reset high at a rising edge the register becomes zero, whatever the mode and data inputs.
- R10: The output is the stored value; input changes between rising edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Operation select for the next edge |
| par_in | input | WIDTH | Parallel load data |
| ser_in | input | 1 | Serial bit entering bit 0 on a left shift |
| q_out | output | WIDTH | Register contents |

## Verification
The assertions take for granted that mode, par_in and ser_in are settled and free of unknowns at each rising edge, since each property compares the new contents with the previous contents and the inputs sampled at that edge. The stimulus changes inputs only on the falling edge, away from the sampling edge, and includes a mid-cycle input burst without an edge to show the output holds. Operand values include negative numbers for the right shifts and a set top bit for the rotate, so the top-bit handling of each mode is exercised.

// File: rtl/msr_pkg.sv
package msr_pkg;
  typedef enum logic [2:0] {
    MODE_HOLD  = 3'b000,
    MODE_CLEAR = 3'b001,
    MODE_ASR   = 3'b010,
    MODE_SHL   = 3'b011,
    MODE_ROL   = 3'b100,
    MODE_LSR   = 3'b101,
    MODE_LOAD  = 3'b110,
    MODE_INV   = 3'b111
  } mode_e;
endpackage

// File: rtl/msr_bit_mux.sv
module msr_bit_mux
  import msr_pkg::*;
(
  input  mode_e mode,
  input  logic  cur,
  input  logic  up_arith,
  input  logic  up_logic,
  input  logic  dn_shift,
  input  logic  dn_rot,
  input  logic  par,
  output logic  nxt
);
  always_comb begin
    unique case (mode)
      MODE_HOLD:  nxt = cur;
      MODE_CLEAR: nxt = 1'b0;
      MODE_ASR:   nxt = up_arith;
      MODE_SHL:   nxt = dn_shift;
      MODE_ROL:   nxt = dn_rot;
      MODE_LSR:   nxt = up_logic;
      MODE_LOAD:  nxt = par;
      MODE_INV:   nxt = ~cur;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/msr_store.sv
module msr_store #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/msr_shift_reg.sv
module msr_shift_reg
  import msr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q_out
);
  localparam int TOP = WIDTH - 1;

  mode_e            mode_sel;
  logic [WIDTH-1:0] q_cur;
  logic [WIDTH-1:0] q_nxt;

  assign mode_sel = mode_e'(mode);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic up_a, up_l, dn_s, dn_r;
    if (i == TOP) begin : g_top
      assign up_a = q_cur[TOP];
      assign up_l = 1'b0;
    end else begin : g_mid_up
      assign up_a = q_cur[i+1];
      assign up_l = q_cur[i+1];
    end
    if (i == 0) begin : g_low
      assign dn_s = ser_in;
      assign dn_r = q_cur[TOP];
    end else begin : g_mid_dn
      assign dn_s = q_cur[i-1];
      assign dn_r = q_cur[i-1];
    end
    msr_bit_mux mux_i (
      .mode     (mode_sel),
      .cur      (q_cur[i]),
      .up_arith (up_a),
      .up_logic (up_l),
      .dn_shift (dn_s),
      .dn_rot   (dn_r),
      .par      (par_in[i]),
      .nxt      (q_nxt[i])
    );
  end

  msr_store #(.WIDTH(WIDTH)) store_i (
    .clk (clk),
    .rst (rst),
    .d   (q_nxt),
    .q   (q_cur)
  );

  assign q_out = q_cur;
endmodule

// File: rtl/msr_shift_reg_chk.sv
module msr_shift_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_in,
  input logic [WIDTH-1:0] q_out
);
  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> q_out == '0);

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b000 |=> q_out == $past(q_out));

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b001 |=> q_out == '0);

  assert_asr_R3: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b010 |=> q_out == {$past(q_out[WIDTH-1]), $past(q_out[WIDTH-1:1])});

  assert_shl_R4: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b011 |=> q_out == {$past(q_out[WIDTH-2:0]), $past(ser_in)});

  assert_rol_R5: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b100 |=> q_out == {$past(q_out[WIDTH-2:0]), $past(q_out[WIDTH-1])});

  assert_lsr_R6: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b101 |=> q_out == {1'b0, $past(q_out[WIDTH-1:1])});

  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b110 |=> q_out == $past(par_in));

  assert_inv_R8: assert property (@(posedge clk) disable iff (rst)
    mode == 3'b111 |=> q_out == ~$past(q_out));
endmodule

bind msr_shift_reg msr_shift_reg_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/msr_shift_reg_tb_top.sv
`timescale 1ns/1ps
module msr_shift_reg_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   mode = 3'b000;
  logic [W-1:0] par_in = '0;
  logic         ser_in = 1'b0;
  logic [W-1:0] q_out;

  int n_vec = 0;
  int n_bad = 0;
  logic [W-1:0] model = '0;

  always #2.5 clk = ~clk;

  msr_shift_reg #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .par_in(par_in),
    .ser_in(ser_in), .q_out(q_out)
  );

  function automatic logic [W-1:0] ref_next(input logic [2:0] m,
      input logic [W-1:0] q, input logic [W-1:0] p, input logic s);
    case (m)
      3'b000: return q;
      3'b001: return '0;
      3'b010: return {q[W-1], q[W-1:1]};
      3'b011: return {q[W-2:0], s};
      3'b100: return {q[W-2:0], q[W-1]};
      3'b101: return {1'b0, q[W-1:1]};
      3'b110: return p;
      default: return ~q;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    n_vec++;
    if (q_out !== exp) begin
      n_bad++;
      $display("FAIL %s: q_out=%b expected=%b", tag, q_out, exp);
    end
  endtask

  task automatic step(input string tag, input logic [2:0] m,
      input logic [W-1:0] p, input logic s);
    @(negedge clk);
    mode = m; par_in = p; ser_in = s;
    model = ref_next(m, model, p, s);
    @(posedge clk); #1;
    check(tag, model);
  endtask

  task automatic t_reset();
    rst = 1'b1; mode = 3'b110; par_in = '1;
    @(posedge clk); #1;
    model = '0;
    check("R9 reset", '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_load();
    step("R7 load 1010", 3'b110, 4'b1010, 1'b0);
    step("R7 load 0101", 3'b110, 4'b0101, 1'b1);
  endtask

  task automatic t_hold();
    step("R1 hold", 3'b000, 4'b1111, 1'b1);
    step("R1 hold again", 3'b000, 4'b0000, 1'b0);
  endtask

  task automatic t_clear();
    step("R2 pre-load", 3'b110, 4'b1101, 1'b0);
    step("R2 clear", 3'b001, 4'b1111, 1'b1);
  endtask

  task automatic t_asr();
    step("R3 load neg", 3'b110, 4'b1000, 1'b0);
    step("R3 asr neg 1", 3'b010, 4'b0000, 1'b0);
    step("R3 asr neg 2", 3'b010, 4'b0000, 1'b1);
    step("R3 load pos", 3'b110, 4'b0110, 1'b0);
    step("R3 asr pos", 3'b010, 4'b0000, 1'b1);
  endtask

  task automatic t_shl();
    step("R4 load", 3'b110, 4'b0001, 1'b0);
    step("R4 shl ser1", 3'b011, 4'b0000, 1'b1);
    step("R4 shl ser0", 3'b011, 4'b1111, 1'b0);
    step("R4 shl ser1 b", 3'b011, 4'b0000, 1'b1);
  endtask

  task automatic t_rol();
    step("R5 load top set", 3'b110, 4'b1001, 1'b0);
    step("R5 rol 1", 3'b100, 4'b0000, 1'b0);
    step("R5 rol 2", 3'b100, 4'b0000, 1'b0);
    step("R5 rol 3", 3'b100, 4'b0000, 1'b1);
  endtask

  task automatic t_lsr();
    step("R6 load neg", 3'b110, 4'b1110, 1'b0);
    step("R6 lsr 1", 3'b101, 4'b0000, 1'b1);
    step("R6 lsr 2", 3'b101, 4'b1111, 1'b1);
  endtask

  task automatic t_inv();
    step("R8 load", 3'b110, 4'b1100, 1'b0);
    step("R8 inv 1", 3'b111, 4'b0000, 1'b0);
    step("R8 inv 2", 3'b111, 4'b1111, 1'b1);
  endtask

  task automatic t_reset_priority();
    step("R9 pre-load", 3'b110, 4'b1011, 1'b0);
    @(negedge clk);
    rst = 1'b1; mode = 3'b111; par_in = 4'b1111;
    @(posedge clk); #1;
    model = '0;
    check("R9 reset over invert", '0);
    @(negedge clk);
    mode = 3'b110;
    @(posedge clk); #1;
    check("R9 reset over load", '0);
    @(negedge clk); rst = 1'b0; mode = 3'b000;
  endtask

  task automatic t_no_edge();
    step("R10 pre-load", 3'b110, 4'b0110, 1'b0);
    @(negedge clk);
    mode = 3'b111; #0.5; mode = 3'b001; par_in = 4'b1001; #0.5;
    mode = 3'b011; ser_in = 1'b1; #0.5;
    check("R10 stable between edges", model);
    mode = 3'b000;
    @(posedge clk); #1;
    check("R10 after hold edge", model);
  endtask

  initial begin
    t_reset();
    t_load();
    t_hold();
    t_clear();
    t_asr();
    t_shl();
    t_rol();
    t_lsr();
    t_inv();
    t_reset_priority();
    t_no_edge();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule